// File: doc/BRIEF.md
# Piecewise-Linear Regamma Curve Evaluator

The block applies a programmable transfer curve to each of the three colour components of a pixel stream. The input range is cut into sixteen octave regions, where region k covers the values from 2^k to 2^(k+1)-1. Each region splits into a power-of-two number of equal segments. Every segment start is a table point that holds a base value and a delta for each colour. The output is found by linear interpolation between the base and the base plus the delta. Inputs below a programmable start octave follow a straight line through zero with a programmable slope. Inputs at or above a programmable end octave follow a line that begins at a programmed end base and rises with a programmed end slope.

Software configures the curve through a single write-only register port. It sets a mode bit, the region bounds, the two slopes and the end base, and a pair of regions per region register. It loads the table by writing a start point and then streaming data words. Six words fill one point, and the point address advances by itself after the sixth word. A three-bit channel mask decides which colour tables accept data. The table should only be loaded while bypass is selected: a load while the curve is active is accepted, but the output of pixels evaluated during the load is undefined.

Top module: `regamma_top`

## Requirements
- R1: After reset, out_valid and out_pix are 0, the block is in bypass, the channel mask is 3'b111, the load point and word position are 0, and the end octave is 16 (no upper linear part).
- R2: A pixel presented with pix_valid high at clock edge t appears on out_pix with out_valid high after edge t+2. out_valid is low two edges after a cycle with pix_valid low.
- R3: With register 0x0 bit 0 clear (bypass), each output component equals its input component.
- R4: Writing register 0x2 sets the load point to bits [6:0] and restarts the word position. Each write to register 0x3 stores bits [15:0] in word order red base, green base, blue base, red delta, green delta, blue delta. The sixth word moves the load point on by one.
- R5: Mask register 0x1 bit 0 enables red, bit 1 green and bit 2 blue. A word for a masked channel leaves that table unchanged, but the word position still advances.
- R6: With the curve on (0x0 bit 0 set) and x < 2^S (S = register 0x4 bits [4:0]), the output is (x*L + 2048) >> 12, saturated to 0xFFFF. L is register 0x5 bits [15:0].
- R7: For 2^S <= x < 2^E (E = register 0x4 bits [12:8]), the region k is the index of the leading one of x. Region register 0x8+p holds region 2p (offset in [6:0], log2 of the segment count in [11:8]) and region 2p+1 (offset in [22:16], log2 count in [27:24]). A count larger than k is treated as k. The point used is offset + ((x - 2^k) >> (k - n)).
- R8: In the curve range the output is base + ((delta*f + 2^(h-1)) >> h), saturated to 0xFFFF. Here h = k - n, f is the low h bits of x - 2^k, and the rounding term is 0 when h = 0.
- R9: For E < 16 and x >= 2^E, the output is B + (((x - 2^E)*M + 2048) >> 12), saturated to 0xFFFF. B is register 0x6 bits [15:0] and M is bits [31:16].
- R10: Each colour component is evaluated from its own table, while the region bounds and slopes are shared by all three components.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 32 | Register write data |
| pix_valid | input | 1 | Input pixel qualifier |
| pix_in | input | 48 | Input pixel: red [15:0], green [31:16], blue [47:32] |
| out_valid | output | 1 | Output pixel qualifier |
| out_pix | output | 48 | Output pixel, same component layout as pix_in |

## Verification
Every pixel result is due two clock edges after the edge that samples it: one register for the region decode, one for the interpolated value. The bench drives a pixel on a falling edge, drops pix_valid on the next falling edge, and reads the result on the falling edge after that. It also reads out_valid on each of the three falling edges after a single-cycle pulse. A register write takes effect at the next rising edge, so the bench writes the table only in bypass and evaluates pixels only after the last write has landed.

// File: rtl/rgc_pkg.sv
`timescale 1ns/1ps
package rgc_pkg;
  localparam int unsigned PIX_W        = 16;
  localparam int unsigned NCH          = 3;
  localparam int unsigned NPTS         = 128;
  localparam int unsigned PT_W         = $clog2(NPTS);
  localparam int unsigned NREGION      = PIX_W;
  localparam int unsigned EXP_W        = $clog2(PIX_W) + 1;
  localparam int unsigned NSEG_W       = $clog2(PIX_W);
  localparam int unsigned SH_W         = $clog2(PIX_W);
  localparam int unsigned SLOPE_W      = 16;
  localparam int unsigned SLOPE_FRAC   = 12;
  localparam int unsigned WORDS_PER_PT = 2 * NCH;
  localparam int unsigned PH_W         = $clog2(WORDS_PER_PT);
  localparam int unsigned REG_W        = 32;
  localparam int unsigned ADDR_W       = 4;
  localparam int unsigned WIDE_W       = PIX_W + SLOPE_W + 1;

  localparam logic [ADDR_W-1:0] A_CTRL   = 4'h0;
  localparam logic [ADDR_W-1:0] A_MASK   = 4'h1;
  localparam logic [ADDR_W-1:0] A_INDEX  = 4'h2;
  localparam logic [ADDR_W-1:0] A_DATA   = 4'h3;
  localparam logic [ADDR_W-1:0] A_BOUNDS = 4'h4;
  localparam logic [ADDR_W-1:0] A_LOWSLP = 4'h5;
  localparam logic [ADDR_W-1:0] A_ENDPT  = 4'h6;
  localparam int unsigned       A_REGION = 8;

  localparam int unsigned F_OFF_EVEN  = 0;
  localparam int unsigned F_SEG_EVEN  = 8;
  localparam int unsigned F_OFF_ODD   = 16;
  localparam int unsigned F_SEG_ODD   = 24;
  localparam int unsigned F_END_EXP   = 8;
  localparam int unsigned F_END_SLOPE = 16;

  typedef enum logic [1:0] {SEL_PASS, SEL_LOW, SEL_CURVE, SEL_HIGH} sel_e;

  typedef struct packed {
    logic                            curve_en;
    logic [EXP_W-1:0]                start_exp;
    logic [EXP_W-1:0]                end_exp;
    logic [SLOPE_W-1:0]              low_slope;
    logic [SLOPE_W-1:0]              end_slope;
    logic [PIX_W-1:0]                end_base;
    logic [NREGION-1:0][PT_W-1:0]    reg_off;
    logic [NREGION-1:0][NSEG_W-1:0]  reg_nseg;
  } curve_cfg_t;

  typedef struct packed {
    sel_e             sel;
    logic [PIX_W-1:0] lin_x;
    logic [PT_W-1:0]  pt;
    logic [PIX_W-2:0] frac;
    logic [SH_W-1:0]  sh;
  } stage_t;

  // index of the highest set bit (0 for x == 0)
  function automatic logic [SH_W-1:0] lead_one(input logic [PIX_W-1:0] x);
    logic [SH_W-1:0] k;
    k = '0;
    for (int i = 0; i < PIX_W; i++) begin
      if (x[i]) k = SH_W'(i);
    end
    return k;
  endfunction

  // fixed-point multiply by a slope, rounded half up
  function automatic logic [WIDE_W-1:0] scale_fix(input logic [PIX_W-1:0] v,
                                                  input logic [SLOPE_W-1:0] m);
    logic [WIDE_W-1:0] p;
    p = WIDE_W'(v) * WIDE_W'(m);
    p = p + (WIDE_W'(1) << (SLOPE_FRAC - 1));
    return p >> SLOPE_FRAC;
  endfunction

  // base plus delta scaled by frac / 2^sh, rounded half up
  function automatic logic [WIDE_W-1:0] interp(input logic [PIX_W-1:0] base,
                                               input logic [PIX_W-1:0] delta,
                                               input logic [PIX_W-2:0] frac,
                                               input logic [SH_W-1:0]  sh);
    logic [WIDE_W-1:0] p;
    logic [WIDE_W-1:0] half;
    p    = WIDE_W'(delta) * WIDE_W'(frac);
    half = (sh == '0) ? '0 : (WIDE_W'(1) << (sh - SH_W'(1)));
    return WIDE_W'(base) + ((p + half) >> sh);
  endfunction

  function automatic logic [PIX_W-1:0] clip(input logic [WIDE_W-1:0] v);
    return (v > WIDE_W'({PIX_W{1'b1}})) ? {PIX_W{1'b1}} : v[PIX_W-1:0];
  endfunction
endpackage

// File: rtl/regamma_cfg.sv
`timescale 1ns/1ps
module regamma_cfg
  import rgc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [REG_W-1:0]    wr_data,
  output curve_cfg_t          cfg,
  output logic [NCH-1:0]      wmask,
  output logic [NCH-1:0]      lut_we_base,
  output logic [NCH-1:0]      lut_we_delta,
  output logic [PT_W-1:0]     lut_addr,
  output logic [PIX_W-1:0]    lut_wdata,
  output logic [PT_W-1:0]     load_pt,
  output logic [PH_W-1:0]     load_phase,
  output logic                data_wr
);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(WORDS_PER_PT - 1);

  assign data_wr   = wr_en && (wr_addr == A_DATA);
  assign lut_addr  = load_pt;
  assign lut_wdata = wr_data[PIX_W-1:0];

  // word position selects channel and base/delta half
  for (genvar c = 0; c < NCH; c++) begin : g_we
    assign lut_we_base[c]  = data_wr && wmask[c] && (load_phase == PH_W'(c));
    assign lut_we_delta[c] = data_wr && wmask[c] && (load_phase == PH_W'(c + NCH));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg         <= '0;
      cfg.end_exp <= EXP_W'(PIX_W);
      wmask       <= '1;
      load_pt     <= '0;
      load_phase  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL:   cfg.curve_en <= wr_data[0];
        A_MASK:   wmask <= wr_data[NCH-1:0];
        A_INDEX: begin
          load_pt    <= wr_data[PT_W-1:0];
          load_phase <= '0;
        end
        A_DATA: begin
          if (load_phase == LAST_PH) begin
            load_phase <= '0;
            load_pt    <= load_pt + PT_W'(1);
          end else begin
            load_phase <= load_phase + PH_W'(1);
          end
        end
        A_BOUNDS: begin
          cfg.start_exp <= wr_data[EXP_W-1:0];
          cfg.end_exp   <= wr_data[F_END_EXP +: EXP_W];
        end
        A_LOWSLP: cfg.low_slope <= wr_data[SLOPE_W-1:0];
        A_ENDPT: begin
          cfg.end_base  <= wr_data[PIX_W-1:0];
          cfg.end_slope <= wr_data[F_END_SLOPE +: SLOPE_W];
        end
        default: begin
          for (int p = 0; p < NREGION / 2; p++) begin
            if (wr_addr == ADDR_W'(A_REGION + p)) begin
              cfg.reg_off[2*p]    <= wr_data[F_OFF_EVEN +: PT_W];
              cfg.reg_nseg[2*p]   <= wr_data[F_SEG_EVEN +: NSEG_W];
              cfg.reg_off[2*p+1]  <= wr_data[F_OFF_ODD +: PT_W];
              cfg.reg_nseg[2*p+1] <= wr_data[F_SEG_ODD +: NSEG_W];
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/regamma_lut.sv
`timescale 1ns/1ps
module regamma_lut
  import rgc_pkg::*;
(
  input  logic              clk,
  input  logic              we_base,
  input  logic              we_delta,
  input  logic [PT_W-1:0]   waddr,
  input  logic [PIX_W-1:0]  wdata,
  input  logic [PT_W-1:0]   raddr,
  output logic [PIX_W-1:0]  base,
  output logic [PIX_W-1:0]  delta
);
  logic [PIX_W-1:0] base_mem  [NPTS];
  logic [PIX_W-1:0] delta_mem [NPTS];

  always_ff @(posedge clk) begin
    if (we_base)  base_mem[waddr]  <= wdata;
    if (we_delta) delta_mem[waddr] <= wdata;
  end

  assign base  = base_mem[raddr];
  assign delta = delta_mem[raddr];
endmodule

// File: rtl/regamma_chan.sv
`timescale 1ns/1ps
module regamma_chan
  import rgc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  curve_cfg_t        cfg,
  input  logic              s1_en,
  input  logic              s2_en,
  input  logic [PIX_W-1:0]  x,
  input  logic              we_base,
  input  logic              we_delta,
  input  logic [PT_W-1:0]   waddr,
  input  logic [PIX_W-1:0]  wdata,
  output logic [PIX_W-1:0]  y
);
  localparam int unsigned POW_W = PIX_W + 1;

  stage_t              nx, st_q;
  logic [SH_W-1:0]     k, nseg_eff, sh;
  logic [NSEG_W-1:0]   nseg_raw;
  logic [PIX_W-1:0]    off, seg;
  logic [POW_W-1:0]    lo_bound, hi_bound;
  logic [PIX_W-1:0]    base_rd, delta_rd, y_nx;

  // stage 1: region and segment decode
  assign k        = lead_one(x);
  assign nseg_raw = cfg.reg_nseg[k];
  assign nseg_eff = (SH_W'(nseg_raw) > k) ? k : SH_W'(nseg_raw);
  assign sh       = k - nseg_eff;
  assign off      = x & ~(PIX_W'(1) << k);
  assign seg      = off >> sh;
  assign lo_bound = POW_W'(1) << cfg.start_exp;
  assign hi_bound = POW_W'(1) << cfg.end_exp;

  always_comb begin
    nx       = '0;
    nx.lin_x = x;
    if (!cfg.curve_en) begin
      nx.sel = SEL_PASS;
    end else if ({1'b0, x} < lo_bound) begin
      nx.sel = SEL_LOW;
    end else if ((cfg.end_exp < EXP_W'(PIX_W)) && ({1'b0, x} >= hi_bound)) begin
      nx.sel   = SEL_HIGH;
      nx.lin_x = x - PIX_W'(hi_bound);
    end else begin
      nx.sel  = SEL_CURVE;
      nx.pt   = cfg.reg_off[k] + PT_W'(seg);
      nx.frac = (PIX_W-1)'(off & ((PIX_W'(1) << sh) - PIX_W'(1)));
      nx.sh   = sh;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= '0;
    else if (s1_en) st_q <= nx;
  end

  regamma_lut u_lut (
    .clk      (clk),
    .we_base  (we_base),
    .we_delta (we_delta),
    .waddr    (waddr),
    .wdata    (wdata),
    .raddr    (st_q.pt),
    .base     (base_rd),
    .delta    (delta_rd)
  );

  // stage 2: evaluate the selected piece
  always_comb begin
    case (st_q.sel)
      SEL_PASS: y_nx = st_q.lin_x;
      SEL_LOW:  y_nx = clip(scale_fix(st_q.lin_x, cfg.low_slope));
      SEL_HIGH: y_nx = clip(WIDE_W'(cfg.end_base) + scale_fix(st_q.lin_x, cfg.end_slope));
      default:  y_nx = clip(interp(base_rd, delta_rd, st_q.frac, st_q.sh));
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     y <= '0;
    else if (s2_en) y <= y_nx;
  end
endmodule

// File: rtl/regamma_top.sv
`timescale 1ns/1ps
module regamma_top
  import rgc_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [ADDR_W-1:0]      cfg_addr,
  input  logic [REG_W-1:0]       cfg_wdata,
  input  logic                   pix_valid,
  input  logic [NCH*PIX_W-1:0]   pix_in,
  output logic                   out_valid,
  output logic [NCH*PIX_W-1:0]   out_pix
);
  curve_cfg_t           cfg;
  logic [NCH-1:0]       wmask, lut_we_base, lut_we_delta;
  logic [PT_W-1:0]      lut_addr, load_pt;
  logic [PIX_W-1:0]     lut_wdata;
  logic [PH_W-1:0]      load_phase;
  logic                 data_wr;
  logic                 curve_en;
  logic                 v_s1;

  assign curve_en = cfg.curve_en;

  regamma_cfg u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (cfg_we),
    .wr_addr      (cfg_addr),
    .wr_data      (cfg_wdata),
    .cfg          (cfg),
    .wmask        (wmask),
    .lut_we_base  (lut_we_base),
    .lut_we_delta (lut_we_delta),
    .lut_addr     (lut_addr),
    .lut_wdata    (lut_wdata),
    .load_pt      (load_pt),
    .load_phase   (load_phase),
    .data_wr      (data_wr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_s1      <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      v_s1      <= pix_valid;
      out_valid <= v_s1;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    regamma_chan u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg      (cfg),
      .s1_en    (pix_valid),
      .s2_en    (v_s1),
      .x        (pix_in[c*PIX_W +: PIX_W]),
      .we_base  (lut_we_base[c]),
      .we_delta (lut_we_delta[c]),
      .waddr    (lut_addr),
      .wdata    (lut_wdata),
      .y        (out_pix[c*PIX_W +: PIX_W])
    );
  end
endmodule

// File: rtl/regamma_checker.sv
`timescale 1ns/1ps
module regamma_checker
  import rgc_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 pix_valid,
  input logic [NCH*PIX_W-1:0] pix_in,
  input logic                 out_valid,
  input logic [NCH*PIX_W-1:0] out_pix,
  input logic                 curve_en,
  input logic                 data_wr,
  input logic [PH_W-1:0]      load_phase,
  input logic [PT_W-1:0]      load_pt,
  input logic [NCH-1:0]       wmask,
  input logic [NCH-1:0]       lut_we_base,
  input logic [NCH-1:0]       lut_we_delta
);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(WORDS_PER_PT - 1);

  p_valid_due_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> ##2 out_valid);

  p_idle_due_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |-> ##2 !out_valid);

  p_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !curve_en) |-> ##2 (out_pix == $past(pix_in, 2)));

  p_word_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && load_phase != LAST_PH) |=>
      (load_phase == $past(load_phase) + PH_W'(1)) && (load_pt == $past(load_pt)));

  p_point_adv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && load_phase == LAST_PH) |=>
      (load_phase == '0) && (load_pt == $past(load_pt) + PT_W'(1)));

  p_phase_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_phase <= LAST_PH);

  p_one_table_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lut_we_delta, lut_we_base}));

  p_mask_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (((lut_we_base | lut_we_delta) & ~wmask) == '0));

  p_zero_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && curve_en && pix_in[PIX_W-1:0] == '0) |-> ##2 (out_pix[PIX_W-1:0] == '0));
endmodule

bind regamma_top regamma_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pix_valid    (pix_valid),
  .pix_in       (pix_in),
  .out_valid    (out_valid),
  .out_pix      (out_pix),
  .curve_en     (curve_en),
  .data_wr      (data_wr),
  .load_phase   (load_phase),
  .load_pt      (load_pt),
  .wmask        (wmask),
  .lut_we_base  (lut_we_base),
  .lut_we_delta (lut_we_delta)
);

// File: tb/test_regamma_top.sv
`timescale 1ns/1ps
module test_regamma_top;
  localparam int MAX_CYC = 20000;
  localparam int NVEC    = 8;
  localparam int NLOAD   = 44;

  // {req, in r, in g, in b, exp r, exp g, exp b}
  localparam logic [99:0] VEC [NVEC] = '{
    {4'd6,  16'd0,    16'd15,   16'd10,    16'd0,     16'd30,    16'd20},    // R6 below start
    {4'd7,  16'd16,   16'd16,   16'd16,    16'd0,     16'd16,    16'd32},    // R7 first point of region 4
    {4'd7,  16'd31,   16'd31,   16'd31,    16'd3840,  16'd3856,  16'd3872},  // R7 clamped count
    {4'd8,  16'd53,   16'd53,   16'd53,    16'd4648,  16'd4704,  16'd4760},  // R8 exact interpolation
    {4'd8,  16'd3884, 16'd3884, 16'd3884,  16'd11046, 16'd11099, 16'd11153}, // R8 half rounds up
    {4'd8,  16'd4095, 16'd4095, 16'd4095,  16'd11072, 16'd11152, 16'd11232}, // R8 last value below end
    {4'd9,  16'd4096, 16'd4197, 16'd65535, 16'd61440, 16'd61491, 16'd65535}, // R9 end line and saturation
    {4'd10, 16'd10,   16'd53,   16'd4197,  16'd20,    16'd4704,  16'd61491}  // R10 mixed components
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        pix_valid = 1'b0;
  logic [47:0] pix_in = '0;
  logic        out_valid;
  logic [47:0] out_pix;
  int          checks = 0;
  int          errors = 0;

  always #2.5 clk = ~clk;

  regamma_top i_regamma_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .pix_valid (pix_valid),
    .pix_in    (pix_in),
    .out_valid (out_valid),
    .out_pix   (out_pix)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic px(input logic [15:0] r, input logic [15:0] g, input logic [15:0] b,
                    output logic [47:0] got);
    pix_valid = 1'b1; pix_in = {b, g, r};
    @(negedge clk);
    pix_valid = 1'b0;
    @(negedge clk);
    got = out_pix;
  endtask

  task automatic px3(input string tag, input logic [15:0] xr, input logic [15:0] xg,
                     input logic [15:0] xb, input logic [15:0] er, input logic [15:0] eg,
                     input logic [15:0] eb);
    logic [47:0] got;
    px(xr, xg, xb, got);
    chk({tag, " red"},   32'(got[15:0]),  32'(er));
    chk({tag, " green"}, 32'(got[31:16]), 32'(eg));
    chk({tag, " blue"},  32'(got[47:32]), 32'(eb));
  endtask

  function automatic logic [6:0] off_of(input int k);
    if (k == 4) return 7'd0;
    if (k >= 5 && k <= 11) return 7'(16 + (k - 5) * 4);
    return 7'd0;
  endfunction

  function automatic logic [3:0] nseg_of(input int k);
    if (k == 4) return 4'd15;
    if (k >= 5 && k <= 11) return 4'd2;
    return 4'd0;
  endfunction

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (MAX_CYC) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state at the ports
    chk("R1 out_valid", 32'(out_valid), 0);
    chk("R1 out_pix",   32'(out_pix),   0);
    // R1 / R3: bypass after reset
    px3("R3 bypass after reset", 16'h1234, 16'hABCD, 16'hFFFF, 16'h1234, 16'hABCD, 16'hFFFF);

    // configuration while bypass
    for (int p = 0; p < 8; p++)
      wr(4'(8 + p), {4'd0, nseg_of(2*p+1), 1'b0, off_of(2*p+1),
                     4'd0, nseg_of(2*p), 1'b0, off_of(2*p)});
    wr(4'h4, {19'd0, 5'd12, 3'd0, 5'd4});
    wr(4'h5, 32'h0000_2000);
    wr(4'h6, {16'h0800, 16'hF000});
    wr(4'h2, 32'd0);
    for (int i = 0; i < NLOAD; i++) begin
      for (int c = 0; c < 3; c++) wr(4'h3, 32'(i * 256 + c * 16));
      for (int c = 0; c < 3; c++) wr(4'h3, 32'(64 * (c + 1)));
    end
    wr(4'h0, 32'd1);

    for (int v = 0; v < NVEC; v++)
      px3($sformatf("R%0d vector %0d", VEC[v][99:96], v),
          VEC[v][95:80], VEC[v][79:64], VEC[v][63:48],
          VEC[v][47:32], VEC[v][31:16], VEC[v][15:0]);

    // R2: valid pulse timing
    pix_valid = 1'b1; pix_in = {16'd16, 16'd16, 16'd16};
    @(negedge clk);
    pix_valid = 1'b0;
    chk("R2 valid after one edge", 32'(out_valid), 0);
    @(negedge clk);
    chk("R2 valid after two edges", 32'(out_valid), 1);
    @(negedge clk);
    chk("R2 valid after three edges", 32'(out_valid), 0);

    // R5: red-only mask, then green-only on the next point (R4 auto-advance)
    wr(4'h0, 32'd0);
    wr(4'h1, 32'd1);
    wr(4'h2, 32'd0);
    for (int w = 0; w < 6; w++) wr(4'h3, (w < 3) ? 32'h7777 : 32'd0);
    wr(4'h1, 32'd2);
    for (int w = 0; w < 6; w++) wr(4'h3, (w < 3) ? 32'h1234 : 32'd0);
    // R4: index write restarts the word order
    wr(4'h1, 32'd7);
    wr(4'h2, 32'd2);
    wr(4'h3, 32'h9999);
    wr(4'h2, 32'd2);
    wr(4'h3, 32'h1111); wr(4'h3, 32'h2222); wr(4'h3, 32'h3333);
    wr(4'h3, 32'd0);    wr(4'h3, 32'd0);    wr(4'h3, 32'd0);
    wr(4'h0, 32'd1);
    px3("R5 masked channels kept", 16'd16, 16'd16, 16'd16, 16'h7777, 16'd16, 16'd32);
    px3("R4 auto advance to point 1", 16'd17, 16'd17, 16'd17, 16'd256, 16'h1234, 16'd288);
    px3("R4 index restarts word order", 16'd18, 16'd18, 16'd18, 16'h1111, 16'h2222, 16'h3333);

    // R3: back to bypass
    wr(4'h0, 32'd0);
    px3("R3 bypass again", 16'd53, 16'd4096, 16'h8001, 16'd53, 16'd4096, 16'h8001);

    summary();
    $finish;
  end
endmodule